// File: doc/BRIEF.md
# Mirrored IO Register Decoder

This block is the byte-wide register file behind an 8 KiB IO window of a small console chip's CPU address map. It selects the window from the high address bits and takes a register index from the low byte. Two ranges of alias indices are folded onto their primary registers before anything else happens. Writes to writable registers are stored. Reads return the stored byte, a live input byte, or the idle value 0xFF, one clock after the read is accepted.

Three indices have side effects. A read of either of two flag-acknowledge indices raises a one-cycle clear pulse toward the interrupt logic. A write to the DMA control register with its go bit set raises a one-cycle DMA start pulse. The sound, display and timer engines live elsewhere. They consume the stored bytes and the pulses.

Top module: `mirio_regblock`

## Requirements
- R1: After reset every stored register holds 0x00, `rd_data_o` is 0xFF, and all three pulse outputs are low.
- R2: `rd_data_o` is registered. It takes the value of the addressed location at the rising edge where `rd_en_i` is high, and it holds its value on every edge where `rd_en_i` is low.
- R3: The window is addresses whose bits [15:13] equal 3'b001, and the offset is bits [12:0]. Offsets 0x00–0x03, 0x08–0x0D, 0x10–0x1C, 0x21–0x23, 0x26 and 0x28–0x2A store the written byte and return it on later reads.
- R4: Offsets 0x04–0x07 act as offsets 0x00–0x03 for both reads and writes.
- R5: Offsets 0x2C–0x2E act as offsets 0x28–0x2A for both reads and writes.
- R6: Offsets 0x0E, 0x0F, 0x1D–0x1F and 0x2B read back a storage byte that writes never change, so they always read 0x00.
- R7: Offset 0x20 returns `ctrl_i` as sampled at the accepting edge. Writes to it change nothing.
- R8: Offset 0x27 returns `irq_status_i` as sampled at the accepting edge. Writes to it change nothing.
- R9: A read of offset 0x24 drives `clr_timer_irq_o` high, and a read of offset 0x25 drives `clr_adma_irq_o` high. Each pulse lasts only the cycle in which `rd_en_i` is high, and both reads return 0xFF. Writes to these offsets raise no pulse and store nothing.
- R10: Offsets 0x30–0x1FFF, and every address outside the window, read 0xFF and ignore writes.
- R11: A write to offset 0x0D with data bit 7 set drives `dma_start_o` high during the write cycle. The byte is also stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 16 | CPU address |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| rd_data_o | output | 8 | Registered read data |
| ctrl_i | input | 8 | Live controller button byte |
| irq_status_i | input | 8 | Live interrupt status byte |
| clr_timer_irq_o | output | 1 | Timer flag clear pulse |
| clr_adma_irq_o | output | 1 | Audio DMA flag clear pulse |
| dma_start_o | output | 1 | DMA start pulse |

## Verification
The hardest case to reach is an alias overwriting its primary. When every offset is written in ascending order, the write through an alias lands last and must win. A second pass writes only the alias offsets and must change exactly their primaries. The bench keeps a model that folds aliases in the same way, so that every offset is checked after both passes. The live inputs change on every read, which shows that offsets 0x20 and 0x27 track their inputs and do not return stale stored bytes.

// File: rtl/mirio_pkg.sv
package mirio_pkg;

    localparam int IDX_W  = 8;
    localparam int DATA_W = 8;

    localparam logic [IDX_W-1:0]  IDX_DMA_CTRL = 8'h0D;
    localparam logic [IDX_W-1:0]  IDX_PAD      = 8'h20;
    localparam logic [IDX_W-1:0]  IDX_CLR_TMR  = 8'h24;
    localparam logic [IDX_W-1:0]  IDX_CLR_ADMA = 8'h25;
    localparam logic [IDX_W-1:0]  IDX_STATUS   = 8'h27;
    localparam int                DMA_GO_BIT   = 7;
    localparam logic [DATA_W-1:0] BUS_IDLE     = 8'hFF;
    localparam logic [IDX_W-1:0]  ALIAS_DIST   = 8'd4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_RW,
        RK_RSVD,
        RK_PAD,
        RK_STAT,
        RK_CLR_TMR,
        RK_CLR_ADMA
    } reg_kind_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        reg_kind_e        kind;
    } dec_t;

    // alias ranges sit a fixed distance above their primaries
    function automatic logic [IDX_W-1:0] fold_idx(input logic [IDX_W-1:0] raw);
        if (raw inside {[8'h04:8'h07], [8'h2C:8'h2E]})
            return raw - ALIAS_DIST;
        return raw;
    endfunction

    function automatic reg_kind_e kind_of(input logic [IDX_W-1:0] idx);
        case (idx) inside
            [8'h00:8'h03], [8'h08:8'h0D], [8'h10:8'h1C],
            [8'h21:8'h23], 8'h26, [8'h28:8'h2A]:      return RK_RW;
            8'h0E, 8'h0F, [8'h1D:8'h1F], 8'h2B:       return RK_RSVD;
            IDX_PAD:                                  return RK_PAD;
            IDX_STATUS:                               return RK_STAT;
            IDX_CLR_TMR:                              return RK_CLR_TMR;
            IDX_CLR_ADMA:                             return RK_CLR_ADMA;
            default:                                  return RK_NONE;
        endcase
    endfunction

    function automatic logic is_backed(input reg_kind_e k);
        return (k == RK_RW) || (k == RK_RSVD);
    endfunction

endpackage

// File: rtl/mirio_addr_dec.sv
module mirio_addr_dec
    import mirio_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 13,
    parameter int WIN_SEL  = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    localparam int SEL_W = ADDR_W - WIN_BITS;
    localparam int HI_W  = WIN_BITS - IDX_W;

    logic             in_win;
    logic             low_page;
    logic [IDX_W-1:0] raw_idx;
    logic [IDX_W-1:0] folded;

    always_comb begin
        in_win   = (addr_i[ADDR_W-1:WIN_BITS] == SEL_W'(WIN_SEL));
        low_page = (addr_i[WIN_BITS-1:IDX_W] == HI_W'(0));
        raw_idx  = addr_i[IDX_W-1:0];
        folded   = fold_idx(raw_idx);
        dec_o.hit  = in_win && low_page;
        dec_o.idx  = folded;
        dec_o.kind = dec_o.hit ? kind_of(folded) : RK_NONE;
    end

endmodule

// File: rtl/mirio_store.sv
module mirio_store
    import mirio_pkg::*;
#(
    parameter int NUM_REGS = 48
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int               SEL_W = $clog2(NUM_REGS);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] cells;
    logic                            in_range;

    assign in_range = (idx_i < LIMIT);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk_i) begin
            if (rst_i)
                q <= '0;
            else if (we_i && in_range && idx_i == IDX_W'(g))
                q <= wdata_i;
        end
        assign cells[g] = q;
    end

    always_comb begin
        rdata_o = '0;
        if (in_range)
            rdata_o = cells[idx_i[SEL_W-1:0]];
    end

endmodule

// File: rtl/mirio_rd_path.sv
module mirio_rd_path
    import mirio_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_en_i,
    input  dec_t              dec_i,
    input  logic [DATA_W-1:0] store_i,
    input  logic [DATA_W-1:0] pad_i,
    input  logic [DATA_W-1:0] stat_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = BUS_IDLE;
        if (dec_i.hit) begin
            if (is_backed(dec_i.kind))
                nxt = store_i;
            else if (dec_i.kind == RK_PAD)
                nxt = pad_i;
            else if (dec_i.kind == RK_STAT)
                nxt = stat_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            rd_data_o <= BUS_IDLE;
        else if (rd_en_i)
            rd_data_o <= nxt;
    end

endmodule

// File: rtl/mirio_regblock.sv
module mirio_regblock
    import mirio_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 13,
    parameter int WIN_SEL  = 1,
    parameter int NUM_REGS = 48
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [DATA_W-1:0] ctrl_i,
    input  logic [DATA_W-1:0] irq_status_i,
    output logic              clr_timer_irq_o,
    output logic              clr_adma_irq_o,
    output logic              dma_start_o
);
    dec_t              dec;
    logic              store_we;
    logic [DATA_W-1:0] store_rd;

    mirio_addr_dec #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .WIN_SEL  (WIN_SEL)
    ) dec_i (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    assign store_we = wr_en_i && dec.hit && (dec.kind == RK_RW);

    mirio_store #(
        .NUM_REGS (NUM_REGS)
    ) store_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (store_we),
        .idx_i   (dec.idx),
        .wdata_i (wr_data_i),
        .rdata_o (store_rd)
    );

    mirio_rd_path rd_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rd_en_i   (rd_en_i),
        .dec_i     (dec),
        .store_i   (store_rd),
        .pad_i     (ctrl_i),
        .stat_i    (irq_status_i),
        .rd_data_o (rd_data_o)
    );

    always_comb begin
        clr_timer_irq_o = rd_en_i && (dec.kind == RK_CLR_TMR);
        clr_adma_irq_o  = rd_en_i && (dec.kind == RK_CLR_ADMA);
        dma_start_o     = store_we && (dec.idx == IDX_DMA_CTRL)
                          && wr_data_i[DMA_GO_BIT];
    end

endmodule

// File: rtl/mirio_regblock_chk.sv
module mirio_regblock_chk
    import mirio_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 13,
    parameter int WIN_SEL  = 1,
    parameter int NUM_REGS = 48
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [DATA_W-1:0] ctrl_i,
    input logic [DATA_W-1:0] irq_status_i,
    input logic              clr_timer_irq_o,
    input logic              clr_adma_irq_o,
    input logic              dma_start_o
);
    localparam int SEL_W = ADDR_W - WIN_BITS;

    logic in_win;
    logic at_pad, at_stat, at_clr;

    assign in_win  = (addr_i[ADDR_W-1:WIN_BITS] == SEL_W'(WIN_SEL));
    assign at_pad  = in_win && (addr_i[WIN_BITS-1:0] == WIN_BITS'(IDX_PAD));
    assign at_stat = in_win && (addr_i[WIN_BITS-1:0] == WIN_BITS'(IDX_STATUS));
    assign at_clr  = in_win && ((addr_i[WIN_BITS-1:0] == WIN_BITS'(IDX_CLR_TMR))
                             || (addr_i[WIN_BITS-1:0] == WIN_BITS'(IDX_CLR_ADMA)));

    AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en_i |=> $stable(rd_data_o)); // R2

    AST_PAD_LIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i && at_pad |=> rd_data_o == $past(ctrl_i)); // R7

    AST_STAT_LIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i && at_stat |=> rd_data_o == $past(irq_status_i)); // R8

    AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({clr_timer_irq_o, clr_adma_irq_o, dma_start_o})); // R9

    AST_CLR_NEEDS_RD: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_timer_irq_o || clr_adma_irq_o) |-> rd_en_i); // R9

    AST_CLR_RD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i && at_clr |=> rd_data_o == BUS_IDLE); // R9

    AST_OUT_WIN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en_i && !in_win |=> rd_data_o == BUS_IDLE); // R10

    AST_DMA_GO: assert property (@(posedge clk_i) disable iff (rst_i)
        dma_start_o |-> wr_en_i && wr_data_i[DMA_GO_BIT]); // R11

endmodule

bind mirio_regblock mirio_regblock_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .WIN_SEL  (WIN_SEL),
    .NUM_REGS (NUM_REGS)
) chk_i (.*);

// File: tb/mirio_regblock_tb_top.sv
`timescale 1ns/1ps
module mirio_regblock_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [15:0] addr_i = 16'h0000;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        rd_en_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic [7:0]  ctrl_i = 8'h00;
    logic [7:0]  irq_status_i = 8'h00;
    logic        clr_timer_irq_o, clr_adma_irq_o, dma_start_o;

    always #2.5 clk_i = ~clk_i;

    mirio_regblock dut_i (.*);

    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 0;
    logic [7:0] salt  = 8'h00;
    logic [7:0] shadow [48];

    // model from the requirements: 0 none, 1 stored, 2 reserved, 3 pad, 4 status, 5/6 clear
    function automatic int bkind(input logic [15:0] a, output logic [7:0] fi);
        logic [12:0] off;
        fi = 8'h00;
        if (a[15:13] != 3'b001) return 0;
        off = a[12:0];
        if (off >= 13'h030) return 0;
        fi = off[7:0];
        if ((fi >= 8'h04 && fi <= 8'h07) || (fi >= 8'h2C && fi <= 8'h2E)) fi = fi - 8'd4;
        if (fi <= 8'h03 || (fi >= 8'h08 && fi <= 8'h0D) || (fi >= 8'h10 && fi <= 8'h1C)
            || (fi >= 8'h21 && fi <= 8'h23) || fi == 8'h26 || (fi >= 8'h28 && fi <= 8'h2A))
            return 1;
        if (fi == 8'h0E || fi == 8'h0F || (fi >= 8'h1D && fi <= 8'h1F) || fi == 8'h2B)
            return 2;
        case (fi)
            8'h20:   return 3;
            8'h27:   return 4;
            8'h24:   return 5;
            8'h25:   return 6;
            default: return 0;
        endcase
    endfunction

    function automatic string rtag(input logic [15:0] a, input int k);
        if (k == 1 && a[12:0] >= 13'h004 && a[12:0] <= 13'h007) return "R4";
        if (k == 1 && a[12:0] >= 13'h02C && a[12:0] <= 13'h02E) return "R5";
        case (k)
            1:       return "R3";
            2:       return "R6";
            3:       return "R7";
            4:       return "R8";
            5, 6:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] fi;
        int k;
        k = bkind(a, fi);
        @(negedge clk_i);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        #1;
        chk((k == 1 && fi == 8'h0D) ? "R11" : rtag(a, k), "dma_start",
            {7'b0, dma_start_o}, (k == 1 && fi == 8'h0D && d[7]) ? 8'h01 : 8'h00);
        chk("R9", "clear pulses on write", {6'b0, clr_timer_irq_o, clr_adma_irq_o}, 8'h00);
        @(negedge clk_i);
        wr_en_i = 1'b0;
        if (k == 1) shadow[fi] = d;
    endtask

    task automatic bus_read(input logic [15:0] a);
        logic [7:0] fi, exp;
        int k;
        string tg;
        k = bkind(a, fi);
        tg = rtag(a, k);
        @(negedge clk_i);
        addr_i = a; rd_en_i = 1'b1;
        ctrl_i = a[7:0] ^ 8'h5A ^ salt;
        irq_status_i = ~a[7:0] ^ salt;
        #1;
        case (k)
            1, 2:    exp = shadow[fi];
            3:       exp = ctrl_i;
            4:       exp = irq_status_i;
            default: exp = 8'hFF;
        endcase
        chk(tg, "clr_timer", {7'b0, clr_timer_irq_o}, (k == 5) ? 8'h01 : 8'h00);
        chk(tg, "clr_adma",  {7'b0, clr_adma_irq_o},  (k == 6) ? 8'h01 : 8'h00);
        @(negedge clk_i);
        rd_en_i = 1'b0;
        #1;
        chk(tg, "clr pulse after read", {6'b0, clr_timer_irq_o, clr_adma_irq_o}, 8'h00);
        chk(tg, $sformatf("rd_data @%h", a), rd_data_o, exp);
    endtask

    task automatic sweep_read();
        for (int o = 0; o < 64; o++) bus_read(16'h2000 + 16'(o));
    endtask

    initial begin
        for (int i = 0; i < 48; i++) shadow[i] = 8'h00;
        repeat (4) @(posedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        #1;
        chk("R1", "rd_data after reset", rd_data_o, 8'hFF);
        chk("R1", "pulses after reset",
            {5'b0, clr_timer_irq_o, clr_adma_irq_o, dma_start_o}, 8'h00);

        // R1: every stored location reads zero
        salt = 8'h11;
        sweep_read();

        // R3..R11: write every offset ascending; aliases land after primaries
        for (int o = 0; o < 64; o++) bus_write(16'h2000 + 16'(o), 8'(o * 7 + 8'h35));
        salt = 8'h22;
        sweep_read();

        // R4 R5: writes through aliases only
        for (int o = 4; o < 8; o++)   bus_write(16'h2000 + 16'(o), 8'(o * 11 + 8'h91));
        for (int o = 44; o < 47; o++) bus_write(16'h2000 + 16'(o), 8'(o * 11 + 8'h91));
        // R11: go bit clear gives no pulse
        bus_write(16'h200D, 8'h7F);
        // R10: writes outside the decoded space change nothing
        bus_write(16'h0003, 8'hAA);
        bus_write(16'h4028, 8'hAB);
        bus_write(16'h2103, 8'hAC);
        salt = 8'h33;
        sweep_read();

        // R10 R9: far offsets and other windows
        bus_read(16'h2100);
        bus_read(16'h3FFF);
        bus_read(16'h20FF);
        bus_read(16'h0024);
        bus_read(16'hE025);
        bus_read(16'h4020);
        bus_read(16'h1FFF);

        // R2: data holds while idle, even as address and inputs move
        bus_read(16'h2001);
        @(negedge clk_i);
        addr_i = 16'h2020; ctrl_i = 8'hC3; irq_status_i = 8'h3C;
        repeat (2) @(negedge clk_i);
        chk("R2", "rd_data hold", rd_data_o, shadow[1]);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule